// File: doc/BRIEF.md
# Debounced Input Conditioner with Double-Edge Events

This block conditions one general-purpose input pin. It first brings the raw pin into the system clock domain, then keeps a filtered copy of the pin level. In filtered mode, the filtered level changes only after the synchronised pin has disagreed with it on a set number of consecutive check strobes. The strobe is a periodic tick, nominally one per millisecond. When the filtered level changes, the block can raise a one-cycle event pulse. The pulse either reports only moves onto the asserted level, or it reports both directions.

A difference between the pin and the filtered level opens a check session. Each tick during the session compares the two. A tick that finds agreement reloads the count. A tick that finds disagreement counts down, and the last step of the countdown commits the new level and closes the session. Because the session always looks for the level opposite to the one held, the reported edge flips after every accepted change. In bypass mode the filter is skipped: the level follows the synchronised pin and the event rule is applied to every change. While the block is disabled, the level tracks the pin and no event is produced, so enabling the block starts from the current pin level.

Top module: `pin_conditioner`

## Requirements
- R1: After reset, state_o is 0, event_o is 0, and no session is open.
- R2: While en_i is 0, state_o follows the synchronised pin and event_o stays 0. When en_i rises, state_o already holds the current synchronised pin level.
- R3: In filtered mode (dbnc_en_i=1), a change is committed on the RISE_LEN-th consecutive disagreeing tick for a 0-to-1 change and on the FALL_LEN-th for a 1-to-0 change. Both default to 2.
- R4: In filtered mode, state_o changes only in the cycle after a tick_i strobe.
- R5: A tick that finds the pin equal to state_o reloads the countdown, so a later change again needs the full count of disagreeing ticks.
- R6: Pin edges arriving while a session is open do not restart the countdown. Only ticks move it.
- R7: On a committed change, event_o fires if dbl_edge_i=1, or if the new level is 1 with act_low_i=0, or if the new level is 0 with act_low_i=1. Otherwise it stays 0.
- R8: Each committed change gives exactly one event_o pulse, one cycle wide, in the same cycle in which state_o takes the new level.
- R9: In bypass mode (dbnc_en_i=0), state_o follows the synchronised pin without ticks, and the R7 rule applies to every change.
- R10: pin_i passes through SYNC_STAGES flops (default 2) before use, so in bypass mode state_o shows a pin change on the (SYNC_STAGES+1)-th rising clock edge after it.
- R11: After a commit, the session closes. Further ticks with the pin steady leave state_o unchanged and produce no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw asynchronous pin |
| tick_i | input | 1 | Check strobe, one cycle wide, nominally once per millisecond |
| en_i | input | 1 | Block enable |
| dbnc_en_i | input | 1 | 1 selects the filtered mode, 0 selects bypass |
| act_low_i | input | 1 | 1 means the asserted pin level is 0 |
| dbl_edge_i | input | 1 | 1 reports changes in both directions |
| state_o | output | 1 | Filtered pin level |
| event_o | output | 1 | One-cycle event pulse |

## Verification
Every cycle, the assertions check four things. A pulse must coincide with a change of state_o. A disabled block must stay silent. Filtered changes must follow a tick. In single-edge mode, a pulse must carry the asserted level. Those checks cannot show how many ticks a commit takes, that agreeing ticks reload the count, that edges during an open session are ignored, or that the synchroniser adds the stated latency. The bench scenarios cover these points: they sweep both polarities, both edge modes and both directions of change, and count ticks and pulses against values worked out from the requirements.

// File: rtl/pin_cond_pkg.sv
package pin_cond_pkg;
  typedef enum logic {SESS_IDLE = 1'b0, SESS_OPEN = 1'b1} sess_e;

  // event qualification for a committed new level
  function automatic logic evt_qualifies(input logic new_lvl, input logic act_low,
                                         input logic dbl);
    return dbl | (new_lvl ^ act_low);
  endfunction
endpackage

// File: rtl/pin_cond_sync.sv
module pin_cond_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/pin_cond_core.sv
module pin_cond_core
  import pin_cond_pkg::*;
#(
  parameter int RISE_LEN = 2,
  parameter int FALL_LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic tick_i,
  input  logic en_i,
  input  logic dbnc_en_i,
  output logic state_o,
  output logic accept_o
);
  localparam int MAX_LEN = (RISE_LEN > FALL_LEN) ? RISE_LEN : FALL_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  // reload depends on the level currently held (0 -> rising count)
  function automatic logic [CNT_W-1:0] reload(input logic lvl);
    return lvl ? CNT_W'(FALL_LEN) : CNT_W'(RISE_LEN);
  endfunction

  sess_e            sess_q;
  logic             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differs, expire, filt_mode;

  always_comb begin
    differs   = raw_i != state_q;
    expire    = cnt_q <= CNT_W'(1);
    filt_mode = en_i & dbnc_en_i;
    if (!en_i)            accept_o = 1'b0;
    else if (!dbnc_en_i)  accept_o = differs;
    else                  accept_o = (sess_q == SESS_OPEN) & tick_i & differs & expire;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sess_q  <= SESS_IDLE;
      state_q <= 1'b0;
      cnt_q   <= reload(1'b0);
    end else if (!filt_mode) begin
      sess_q  <= SESS_IDLE;
      state_q <= raw_i;
      cnt_q   <= reload(raw_i);
    end else begin
      unique case (sess_q)
        SESS_IDLE: if (differs) sess_q <= SESS_OPEN;
        SESS_OPEN: if (tick_i) begin
          if (!differs) begin
            cnt_q <= reload(state_q);
          end else if (expire) begin
            state_q <= raw_i;
            cnt_q   <= reload(raw_i);
            sess_q  <= SESS_IDLE;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: sess_q <= SESS_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/pin_cond_evt.sv
module pin_cond_evt
  import pin_cond_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic new_lvl_i,
  input  logic act_low_i,
  input  logic dbl_edge_i,
  output logic event_o
);
  logic event_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) event_q <= 1'b0;
    else         event_q <= accept_i & evt_qualifies(new_lvl_i, act_low_i, dbl_edge_i);

  assign event_o = event_q;
endmodule

// File: rtl/pin_conditioner.sv
module pin_conditioner #(
  parameter int SYNC_STAGES = 2,
  parameter int RISE_LEN    = 2,
  parameter int FALL_LEN    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic tick_i,
  input  logic en_i,
  input  logic dbnc_en_i,
  input  logic act_low_i,
  input  logic dbl_edge_i,
  output logic state_o,
  output logic event_o
);
  logic raw_s, accept;

  pin_cond_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (raw_s)
  );

  pin_cond_core #(.RISE_LEN(RISE_LEN), .FALL_LEN(FALL_LEN)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raw_i    (raw_s),
    .tick_i   (tick_i),
    .en_i     (en_i),
    .dbnc_en_i(dbnc_en_i),
    .state_o  (state_o),
    .accept_o (accept)
  );

  pin_cond_evt u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .new_lvl_i (raw_s),
    .act_low_i (act_low_i),
    .dbl_edge_i(dbl_edge_i),
    .event_o   (event_o)
  );
endmodule

// File: rtl/pin_conditioner_chk.sv
module pin_conditioner_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic en_i,
  input logic dbnc_en_i,
  input logic act_low_i,
  input logic dbl_edge_i,
  input logic state_o,
  input logic event_o
);
  AST_EVT_WITH_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> (state_o != $past(state_o)));  // R8

  AST_DIS_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !event_o);  // R2

  AST_FILT_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i && dbnc_en_i) && (state_o != $past(state_o))) |-> $past(tick_i));  // R4

  AST_POL_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !$past(dbl_edge_i)) |-> (state_o == !$past(act_low_i)));  // R7
endmodule

bind pin_conditioner pin_conditioner_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .en_i      (en_i),
  .dbnc_en_i (dbnc_en_i),
  .act_low_i (act_low_i),
  .dbl_edge_i(dbl_edge_i),
  .state_o   (state_o),
  .event_o   (event_o)
);

// File: tb/pin_conditioner_tb_top.sv
module pin_conditioner_tb_top;
  localparam int SYNC = 2;
  localparam int LEN  = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pin = 1'b0, tick = 1'b0, en = 1'b0, dbnc = 1'b1, al = 1'b0, dbl = 1'b0;
  logic state_o, event_o;
  int   n_chk = 0, n_bad = 0, ev_cnt = 0, ev_run = 0, ev_wide = 0;

  always #2 clk = ~clk;

  pin_conditioner dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .tick_i(tick), .en_i(en),
    .dbnc_en_i(dbnc), .act_low_i(al), .dbl_edge_i(dbl),
    .state_o(state_o), .event_o(event_o)
  );

  always @(posedge clk) begin
    if (rst_ni && event_o) begin
      ev_cnt <= ev_cnt + 1;
      ev_run <= ev_run + 1;
      if (ev_run >= 1) ev_wide <= ev_wide + 1;
    end else ev_run <= 0;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    cyc(1);
  endtask

  task automatic settle(); cyc(SYNC + 3); endtask

  // start from a known level with the block enabled
  task automatic arm(input logic lvl, input logic filt);
    @(negedge clk) en = 1'b0; pin = lvl; dbnc = filt;
    settle();
    @(negedge clk) en = 1'b1;
    cyc(2);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e0, exp_e;
    logic nl;
    cyc(3);
    chk(state_o == 1'b0 && event_o == 1'b0, "R1 reset outputs", {state_o, event_o}, 0);
    @(negedge clk) rst_ni = 1'b1;
    cyc(2);
    chk(state_o == 1'b0, "R1 state after release", state_o, 0);

    // R2 disabled tracking, no events
    e0 = ev_cnt;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk) pin = ~pin;
      settle();
      chk(state_o == pin, "R2 disabled follows pin", state_o, pin);
    end
    chk(ev_cnt == e0, "R2 no events while disabled", ev_cnt - e0, 0);
    @(negedge clk) pin = 1'b1;
    settle();
    @(negedge clk) en = 1'b1;
    cyc(1);
    chk(state_o == 1'b1, "R2 enable loads pin level", state_o, 1);

    // filtered sweep: R3 R4 R7 R8 R11
    for (int a = 0; a < 2; a++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 2; s++) begin
          al = a[0]; dbl = d[0];
          arm(s[0], 1'b1);
          nl = ~s[0];
          e0 = ev_cnt;
          @(negedge clk) pin = nl;
          settle();
          chk(state_o == s[0], "R4 no change without tick", state_o, s);
          for (int t = 1; t < LEN; t++) begin
            do_tick();
            chk(state_o == s[0], "R3 held before count done", state_o, s);
          end
          do_tick();
          chk(state_o == nl, "R3 committed on last tick", state_o, nl);
          exp_e = (d[0] | (nl ^ a[0])) ? 1 : 0;
          chk(ev_cnt - e0 == exp_e, "R7 event qualification", ev_cnt - e0, exp_e);
          do_tick(); do_tick();
          chk(state_o == nl && ev_cnt - e0 == exp_e, "R11 session closed", ev_cnt - e0, exp_e);
        end
    chk(ev_wide == 0, "R8 pulse one cycle", ev_wide, 0);

    // R5 reload on agreement
    al = 1'b0; dbl = 1'b1;
    arm(1'b0, 1'b1);
    @(negedge clk) pin = 1'b1; settle();
    do_tick();
    @(negedge clk) pin = 1'b0; settle();
    do_tick();
    @(negedge clk) pin = 1'b1; settle();
    do_tick();
    chk(state_o == 1'b0, "R5 reload needs full count", state_o, 0);
    do_tick();
    chk(state_o == 1'b1, "R5 commit after reload", state_o, 1);

    // R6 edges inside a session do not restart it
    arm(1'b0, 1'b1);
    @(negedge clk) pin = 1'b1; settle();
    do_tick();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) pin = 1'b0; settle();
      @(negedge clk) pin = 1'b1; settle();
    end
    chk(state_o == 1'b0, "R6 no commit from edges", state_o, 0);
    do_tick();
    chk(state_o == 1'b1, "R6 count kept through edges", state_o, 1);

    // R9 bypass sweep
    for (int a = 0; a < 2; a++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 2; s++) begin
          al = a[0]; dbl = d[0];
          arm(s[0], 1'b0);
          nl = ~s[0];
          e0 = ev_cnt;
          @(negedge clk) pin = nl;
          settle();
          chk(state_o == nl, "R9 bypass follows pin", state_o, nl);
          exp_e = (d[0] | (nl ^ a[0])) ? 1 : 0;
          chk(ev_cnt - e0 == exp_e, "R9 bypass event rule", ev_cnt - e0, exp_e);
        end

    // R10 synchroniser latency in bypass
    arm(1'b0, 1'b0);
    @(negedge clk) pin = 1'b1;
    cyc(SYNC);
    chk(state_o == 1'b0, "R10 not yet through sync", state_o, 0);
    cyc(1);
    chk(state_o == 1'b1, "R10 visible after sync", state_o, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule